// File: doc/BRIEF.md
# USB Start-of-Frame Number Capture

This block sits behind a USB receive front end that has already recovered the line bits, removed stuffing and packed them into bytes. It watches each packet's byte stream for a Start of Frame token, pulls the 11-bit frame number and its 5-bit check field out of the two bytes that follow the token's PID, and checks them. The result goes into two read-only byte registers: a low byte with frame bits 7..0, and a high byte with frame bits 10..8 plus two status flags. One flag reports a good check and the other reports a corrupted one.

The frame interrupt is raised as soon as the PID byte is accepted, which is before the frame number or its check field arrive. Software therefore learns that a new frame has started at the earliest point. The frame register is loaded on every complete token, even one that fails the check, and the two flags show which case occurred. The interrupt flag is sticky. It is cleared by a write-one-to-clear strobe, and an enable input gates the interrupt line.

Top module: `sof_frame_capture`

## Requirements
- R1: After a synchronous reset, `frame_lo` and `frame_hi` read 00h, and `irq_pending` and `irq` are 0.
- R2: When the first valid byte of a packet is A5h, `irq_pending` is 1 from the clock edge that accepts that byte. This happens before either following byte arrives.
- R3: The second byte of the packet holds frame bits 7..0. Bits 2..0 of the third byte hold frame bits 10..8. Both registers load on the edge that accepts the third byte: `frame_lo` = frame[7:0] and `frame_hi[2:0]` = frame[10:8].
- R4: The check field is bits 7..3 of the third byte, with bit 3 sent first. It is the inverted remainder of the polynomial x^5+x^2+1, seeded with 11111b, over the 11 frame bits taken LSB first. The remainder bit of degree 4 is sent first. A matching token sets `frame_hi[5]`=1 and `frame_hi[4]`=0.
- R5: A token whose check field does not match sets `frame_hi[4]`=1 and `frame_hi[5]`=0, and the frame number is still loaded.
- R6: Bits 7, 6 and 3 of `frame_hi` always read 0.
- R7: If a packet ends (`rx_active` low) before the third byte arrives, both registers keep their values. A pending interrupt stays set.
- R8: A first byte other than A5h, including any byte whose upper nibble is not the complement of its lower nibble, sets no interrupt and changes no register for that whole packet.
- R9: Only the first byte of a packet is taken as a PID. Bytes after the third byte are ignored.
- R10: `irq_clr` high at a clock edge clears `irq_pending`. If an SOF PID is accepted on the same edge, the flag stays set.
- R11: `irq` is registered. At each edge it takes the value (next `irq_pending` AND `irq_en`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_active | input | 1 | High for the duration of one received packet |
| rx_valid | input | 1 | Strobe: `rx_data` holds a byte this cycle |
| rx_data | input | 8 | Received byte, first byte of a packet is the PID |
| irq_en | input | 1 | Interrupt line enable |
| irq_clr | input | 1 | Write-one-to-clear for the sticky interrupt flag |
| frame_lo | output | 8 | Frame number bits 7..0 |
| frame_hi | output | 8 | {0,0,check-good,check-error,0,frame[10:8]} |
| irq_pending | output | 1 | Sticky SOF interrupt flag |
| irq | output | 1 | Gated interrupt request |

## Verification
A parser left in the wrong state shows up at the ports within one packet. It either raises `irq_pending` on a non-SOF or mid-packet byte, or it loads the registers from the wrong byte pair, and both show up on the edge after the offending byte. A wrong check seed or feedback tap shows as the error flag set on a correctly formed token, on the edge that accepts its last byte. A sweep over all 2048 frame numbers catches this together with any misplaced frame bit. Stale register state after a truncated packet shows as a changed `frame_lo` or `frame_hi` read after the packet ends.

// File: rtl/sof_cap_pkg.sv
`timescale 1ns/100ps
package sof_cap_pkg;
  localparam int BYTE_W    = 8;
  localparam int FRAME_W   = 11;
  localparam int CHK_W     = 5;
  localparam int NIB_W     = BYTE_W / 2;
  localparam logic [NIB_W-1:0] PID_SOF = 4'b0101;
  localparam logic [CHK_W-1:0] CHK_POLY   = 5'b00101;
  localparam logic [CHK_W-1:0] CHK_SEED   = 5'b11111;
  localparam logic [CHK_W-1:0] CHK_RESID  = 5'b01100;
  localparam int HI_GOOD_BIT = 5;
  localparam int HI_BAD_BIT  = 4;

  typedef enum logic [1:0] {
    PS_PID   = 2'd0,
    PS_LO    = 2'd1,
    PS_HI    = 2'd2,
    PS_DRAIN = 2'd3
  } parse_st_e;
endpackage

// File: rtl/sof_token_parser.sv
`timescale 1ns/100ps
module sof_token_parser
  import sof_cap_pkg::*;
#(
  parameter int B_W = BYTE_W,
  parameter logic [B_W/2-1:0] SOF_CODE = PID_SOF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_active,
  input  logic             rx_valid,
  input  logic [B_W-1:0]   rx_data,
  output logic             pid_hit,
  output logic             word_done,
  output logic [2*B_W-1:0] word
);
  localparam int H_W = B_W / 2;

  parse_st_e       st_q;
  logic [B_W-1:0]  lo_q;
  logic            take;
  logic            pid_form_ok;
  logic            pid_is_sof;

  assign take        = rx_active && rx_valid;
  assign pid_form_ok = (rx_data[B_W-1:H_W] == ~rx_data[H_W-1:0]);
  assign pid_is_sof  = pid_form_ok && (rx_data[H_W-1:0] == SOF_CODE);

  always_ff @(posedge clk) begin
    if (rst || !rx_active) begin
      st_q <= PS_PID;
    end else if (rx_valid) begin
      case (st_q)
        PS_PID:  st_q <= pid_is_sof ? PS_LO : PS_DRAIN;
        PS_LO:   st_q <= PS_HI;
        PS_HI:   st_q <= PS_DRAIN;
        default: st_q <= PS_DRAIN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
    end else if (take && st_q == PS_LO) begin
      lo_q <= rx_data;
    end
  end

  assign pid_hit   = take && (st_q == PS_PID) && pid_is_sof;
  assign word_done = take && (st_q == PS_HI);
  assign word      = {rx_data, lo_q};
endmodule

// File: rtl/sof_crc_residual.sv
`timescale 1ns/100ps
module sof_crc_residual #(
  parameter int LEN = 16,
  parameter int W   = 5,
  parameter logic [W-1:0] POLY = 5'b00101,
  parameter logic [W-1:0] SEED = 5'b11111
) (
  input  logic [LEN-1:0] bits,
  output logic [W-1:0]   rem
);
  for (genvar i = 0; i < LEN; i++) begin : g_step
    logic [W-1:0] cur;
    logic [W-1:0] nxt;
    logic         fb;
    if (i == 0) begin : g_first
      assign cur = SEED;
    end else begin : g_rest
      assign cur = g_step[i-1].nxt;
    end
    assign fb  = bits[i] ^ cur[W-1];
    assign nxt = {cur[W-2:0], 1'b0} ^ (fb ? POLY : '0);
  end

  assign rem = g_step[LEN-1].nxt;
endmodule

// File: rtl/sof_status_regs.sv
`timescale 1ns/100ps
module sof_status_regs
  import sof_cap_pkg::*;
#(
  parameter int B_W   = BYTE_W,
  parameter int F_W   = FRAME_W,
  parameter int GOOD_BIT = HI_GOOD_BIT,
  parameter int BAD_BIT  = HI_BAD_BIT
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pid_hit,
  input  logic           word_done,
  input  logic [F_W-1:0] frame,
  input  logic           chk_good,
  input  logic           irq_en,
  input  logic           irq_clr,
  output logic [B_W-1:0] frame_lo,
  output logic [B_W-1:0] frame_hi,
  output logic           irq_pending,
  output logic           irq
);
  localparam int UP_W = F_W - B_W;

  logic [B_W-1:0]  lo_q;
  logic [UP_W-1:0] up_q;
  logic            good_q;
  logic            bad_q;
  logic            flag_q;
  logic            irq_q;
  logic            flag_d;

  assign flag_d = pid_hit || (flag_q && !irq_clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q   <= '0;
      up_q   <= '0;
      good_q <= 1'b0;
      bad_q  <= 1'b0;
    end else if (word_done) begin
      lo_q   <= frame[B_W-1:0];
      up_q   <= frame[F_W-1:B_W];
      good_q <= chk_good;
      bad_q  <= !chk_good;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_d && irq_en;
    end
  end

  for (genvar b = 0; b < B_W; b++) begin : g_hi
    if (b < UP_W) begin : g_num
      assign frame_hi[b] = up_q[b];
    end else if (b == GOOD_BIT) begin : g_good
      assign frame_hi[b] = good_q;
    end else if (b == BAD_BIT) begin : g_bad
      assign frame_hi[b] = bad_q;
    end else begin : g_zero
      assign frame_hi[b] = 1'b0;
    end
  end

  assign frame_lo    = lo_q;
  assign irq_pending = flag_q;
  assign irq         = irq_q;
endmodule

// File: rtl/sof_frame_capture.sv
`timescale 1ns/100ps
module sof_frame_capture
  import sof_cap_pkg::*;
#(
  parameter int B_W = BYTE_W,
  parameter int C_W = CHK_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rx_active,
  input  logic           rx_valid,
  input  logic [B_W-1:0] rx_data,
  input  logic           irq_en,
  input  logic           irq_clr,
  output logic [B_W-1:0] frame_lo,
  output logic [B_W-1:0] frame_hi,
  output logic           irq_pending,
  output logic           irq
);
  localparam int WORD_W = 2 * B_W;
  localparam int F_W    = WORD_W - C_W;

  logic              sof_pid_hit;
  logic              sof_word_done;
  logic [WORD_W-1:0] sof_word;
  logic [C_W-1:0]    sof_rem;
  logic              sof_chk_good;

  sof_token_parser #(.B_W(B_W), .SOF_CODE(PID_SOF)) u_parser (
    .clk       (clk),
    .rst       (rst),
    .rx_active (rx_active),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .pid_hit   (sof_pid_hit),
    .word_done (sof_word_done),
    .word      (sof_word)
  );

  sof_crc_residual #(.LEN(WORD_W), .W(C_W), .POLY(CHK_POLY), .SEED(CHK_SEED)) u_crc (
    .bits (sof_word),
    .rem  (sof_rem)
  );

  assign sof_chk_good = (sof_rem == CHK_RESID);

  sof_status_regs #(.B_W(B_W), .F_W(F_W), .GOOD_BIT(HI_GOOD_BIT), .BAD_BIT(HI_BAD_BIT)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .pid_hit     (sof_pid_hit),
    .word_done   (sof_word_done),
    .frame       (sof_word[F_W-1:0]),
    .chk_good    (sof_chk_good),
    .irq_en      (irq_en),
    .irq_clr     (irq_clr),
    .frame_lo    (frame_lo),
    .frame_hi    (frame_hi),
    .irq_pending (irq_pending),
    .irq         (irq)
  );
endmodule

// File: rtl/sof_capture_checker.sv
`timescale 1ns/100ps
module sof_capture_checker (
  input logic       clk,
  input logic       rst,
  input logic [7:0] rx_data,
  input logic       irq_en,
  input logic       irq_clr,
  input logic       pid_hit,
  input logic       word_done,
  input logic [7:0] frame_lo,
  input logic [7:0] frame_hi,
  input logic       irq_pending,
  input logic       irq
);
  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (rst)
    frame_hi[7:6] == 2'b00 && frame_hi[3] == 1'b0);

  p_flags_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
    !(frame_hi[5] && frame_hi[4]));

  p_done_sets_one_flag_r4: assert property (@(posedge clk) disable iff (rst)
    word_done |=> $countones(frame_hi[5:4]) == 1);

  p_pid_sets_flag_r2: assert property (@(posedge clk) disable iff (rst)
    pid_hit |=> irq_pending);

  p_pid_only_sof_r8: assert property (@(posedge clk) disable iff (rst)
    pid_hit |-> rx_data == 8'hA5);

  p_hold_without_token_r7: assert property (@(posedge clk) disable iff (rst)
    !word_done |=> $stable(frame_lo) && $stable(frame_hi));

  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (irq_clr && !pid_hit) |=> !irq_pending);

  p_irq_gate_r11: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq);
endmodule

bind sof_frame_capture sof_capture_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .rx_data     (rx_data),
  .irq_en      (irq_en),
  .irq_clr     (irq_clr),
  .pid_hit     (sof_pid_hit),
  .word_done   (sof_word_done),
  .frame_lo    (frame_lo),
  .frame_hi    (frame_hi),
  .irq_pending (irq_pending),
  .irq         (irq)
);

// File: tb/sim_sof_frame_capture.sv
`timescale 1ns/100ps
module sim_sof_frame_capture;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_active = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic       irq_en = 1'b0;
  logic       irq_clr = 1'b0;
  logic [7:0] frame_lo;
  logic [7:0] frame_hi;
  logic       irq_pending;
  logic       irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  sof_frame_capture u0 (
    .clk(clk), .rst(rst), .rx_active(rx_active), .rx_valid(rx_valid),
    .rx_data(rx_data), .irq_en(irq_en), .irq_clr(irq_clr),
    .frame_lo(frame_lo), .frame_hi(frame_hi),
    .irq_pending(irq_pending), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Transmitted check field: inverted remainder, degree-4 bit placed first (bit 3).
  function automatic logic [4:0] chk_field(input logic [10:0] f);
    logic [4:0] c = 5'b11111;
    logic [4:0] r;
    for (int i = 0; i < 11; i++) begin
      logic fb = f[i] ^ c[4];
      c = {c[3:0], 1'b0};
      if (fb) c = c ^ 5'b00101;
    end
    for (int i = 0; i < 5; i++) r[i] = ~c[4-i];
    return r;
  endfunction

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_active = 1'b1;
    rx_valid  = 1'b1;
    rx_data   = b;
    @(negedge clk);
    rx_valid  = 1'b0;
  endtask

  task automatic end_pkt();
    rx_active = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_clr();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic send_sof(input logic [10:0] f, input logic [4:0] flip);
    logic [4:0] fld = chk_field(f) ^ flip;
    send_byte(8'hA5);
    send_byte(f[7:0]);
    send_byte({fld, f[10:8]});
    end_pkt();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] lo_keep, hi_keep;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(frame_lo == 8'h00, "R1", frame_lo, 0);
    chk(frame_hi == 8'h00, "R1", frame_hi, 0);
    chk(irq_pending == 1'b0 && irq == 1'b0, "R1", {irq_pending, irq}, 0);

    irq_en = 1'b1;
    // R2 interrupt right after PID, R7 truncated packet
    send_byte(8'hA5);
    chk(irq_pending == 1'b1, "R2", irq_pending, 1);
    chk(irq == 1'b1, "R11", irq, 1);
    end_pkt();
    chk(frame_lo == 8'h00 && frame_hi == 8'h00, "R7", {frame_hi, frame_lo}, 0);
    chk(irq_pending == 1'b1, "R7", irq_pending, 1);
    pulse_clr();
    chk(irq_pending == 1'b0 && irq == 1'b0, "R10", {irq_pending, irq}, 0);
    send_byte(8'hA5);
    send_byte(8'h3C);
    end_pkt();
    chk(frame_lo == 8'h00 && frame_hi == 8'h00, "R7", {frame_hi, frame_lo}, 0);
    pulse_clr();

    // R3 R4 R6 sweep of every frame number with a correct check field
    for (int f = 0; f < 2048; f++) begin
      logic [10:0] fv = f[10:0];
      send_sof(fv, 5'b0);
      chk(frame_lo == fv[7:0], "R3", frame_lo, fv[7:0]);
      chk(frame_hi == {5'b00100, fv[10:8]}, "R4", frame_hi, {5'b00100, fv[10:8]});
      chk(irq_pending == 1'b1, "R2", irq_pending, 1);
      pulse_clr();
    end

    // R5 corrupted check field still loads the frame number
    for (int f = 0; f < 2048; f += 37) begin
      logic [10:0] fv = f[10:0];
      logic [4:0] flip = 5'b00001 << (f % 5);
      send_sof(fv, flip);
      chk(frame_lo == fv[7:0], "R5", frame_lo, fv[7:0]);
      chk(frame_hi == {5'b00010, fv[10:8]}, "R5", frame_hi, {5'b00010, fv[10:8]});
    end
    send_sof(11'h5A3, 5'b0);
    send_byte(8'hA5);
    send_byte(8'hA3);
    send_byte({chk_field(11'h5A3), 3'b100});
    end_pkt();
    chk(frame_hi == 8'h14 && frame_lo == 8'hA3, "R5", {frame_hi, frame_lo}, 16'h14A3);
    pulse_clr();

    // R8 every other first byte is ignored
    lo_keep = frame_lo;
    hi_keep = frame_hi;
    for (int p = 0; p < 256; p++) begin
      if (p != 8'hA5) begin
        send_byte(p[7:0]);
        send_byte(8'h55);
        send_byte(8'h12);
        end_pkt();
        chk(irq_pending == 1'b0, "R8", irq_pending, 0);
        chk(frame_lo == lo_keep && frame_hi == hi_keep, "R8",
            {frame_hi, frame_lo}, {hi_keep, lo_keep});
      end
    end

    // R9 PID only at packet start, trailing bytes ignored
    send_byte(8'hD2);
    send_byte(8'hA5);
    send_byte(8'h00);
    send_byte(8'h00);
    end_pkt();
    chk(irq_pending == 1'b0, "R9", irq_pending, 0);
    send_byte(8'hA5);
    send_byte(8'h7E);
    send_byte({chk_field(11'h17E), 3'b001});
    send_byte(8'hFF);
    send_byte(8'hFF);
    end_pkt();
    chk(frame_lo == 8'h7E && frame_hi == 8'h21, "R9", {frame_hi, frame_lo}, 16'h217E);
    pulse_clr();

    // R10 a PID on the same edge as a clear keeps the flag set
    @(negedge clk);
    rx_active = 1'b1; rx_valid = 1'b1; rx_data = 8'hA5; irq_clr = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; irq_clr = 1'b0;
    chk(irq_pending == 1'b1, "R10", irq_pending, 1);
    end_pkt();
    pulse_clr();

    // R11 the enable gates the line with one register of delay
    irq_en = 1'b0;
    send_byte(8'hA5);
    end_pkt();
    chk(irq_pending == 1'b1 && irq == 1'b0, "R11", {irq_pending, irq}, 2);
    irq_en = 1'b1;
    chk(irq == 1'b0, "R11", irq, 0);
    @(negedge clk);
    chk(irq == 1'b1, "R11", irq, 1);
    irq_en = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0 && irq_pending == 1'b1, "R11", {irq_pending, irq}, 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule